// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the clock and data wires of a two-wire open-collector keyboard link and samples both in the system clock domain. Each wire passes through a synchroniser and a stability filter. Falling edges of the cleaned keyboard clock then shift in one 11-bit frame.

Each frame has a 0 start bit, eight data bits sent least significant bit first, an odd parity bit and a 1 stop bit. After the last bit, the block either presents the byte with a one-cycle valid strobe, or raises a one-cycle error pulse when a framing or parity check fails.

A host inhibit input drives an open-drain enable that pulls the keyboard clock low. While the line is held low the keyboard holds back its data, and any frame in progress is abandoned. A frame that stalls for too long in the middle is also abandoned, and an error is reported.

Top module: `ps2_rx`

## Requirements
- R1: After reset, rx_valid and rx_err are 0, rx_data is 0x00 and ps2_clk_oe is 0.
- R2: A frame with a 0 start bit, data LSB first, odd parity over the data and parity bits, and a 1 stop bit produces exactly one rx_valid pulse one cycle wide, with rx_data equal to the byte and no rx_err.
- R3: A frame whose data plus parity bits hold an even number of ones produces one rx_err pulse and no rx_valid, and rx_data keeps the last good byte.
- R4: A frame whose stop bit reads 0 produces one rx_err pulse and no rx_valid.
- R5: A start bit that reads 1 at the first falling clock edge produces one rx_err pulse at once. The receiver keeps waiting for a start bit, and a following good frame decodes correctly.
- R6: If no falling clock edge arrives for TIMEOUT_CYC cycles in the middle of a frame, one rx_err pulse is raised and the bit position resets, so the next frame decodes correctly.
- R7: ps2_clk_oe equals inhibit_i delayed by one clock. While inhibit_i is 1, rx_valid and rx_err stay 0, and a partly received frame is discarded without any pulse.
- R8: A low pulse on either line that lasts fewer than FILT_LEN system clocks is not taken as a level change and does not disturb the next frame.
- R9: rx_valid and rx_err are never 1 in the same cycle, and neither stays 1 for two cycles in a row. rx_data changes only in a cycle where rx_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_i | input | 1 | Sampled level of the keyboard clock wire |
| ps2_dat_i | input | 1 | Sampled level of the keyboard data wire |
| inhibit_i | input | 1 | Host request to hold the keyboard clock low |
| ps2_clk_oe | output | 1 | Open-drain enable; 1 pulls the clock wire low |
| rx_data | output | 8 | Last correctly received byte |
| rx_valid | output | 1 | One-cycle strobe: new byte on rx_data |
| rx_err | output | 1 | One-cycle pulse: frame rejected |

## Verification
The bench drives frames with a bad parity, a stop bit at 0, a stray start bit at 1, a stalled half frame and a half frame cut off by inhibit. Each is followed by a good frame, because a receiver that failed to reset its bit position would misalign and mis-decode that next byte. It also injects short glitches on both wires: a filter that let them through would count an extra edge or a false bit and corrupt the byte. It also checks that rx_data holds the last good byte after a rejected frame, and that no strobe appears while the host inhibits the link.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
   localparam int FRAME_BITS = 11;
   localparam int DATA_BITS  = 8;
   typedef logic [DATA_BITS-1:0] rx_byte_t;
endpackage

// File: rtl/ps2_deglitch.sv
module ps2_deglitch #(
   parameter int STAGES   = 2,
   parameter int FILT_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("ps2_deglitch: STAGES must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("ps2_deglitch: FILT_LEN must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic [CW-1:0]     run_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[0] <= 1'b1;
            else        sync_q[0] <= raw;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[i] <= 1'b1;
            else        sync_q[i] <= sync_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clean <= 1'b1;
         run_q <= '0;
      end else if (sync_q[STAGES-1] != clean) begin
         if (run_q == CW'(FILT_LEN-1)) begin
            clean <= sync_q[STAGES-1];
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end else begin
         run_q <= '0;
      end
   end
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
   import ps2_rx_pkg::*;
#(
   parameter int TIMEOUT_CYC = 10000
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     fall,
   input  logic     dat,
   input  logic     inhibit,
   output rx_byte_t data,
   output logic     valid,
   output logic     err
);
   localparam int TW = $clog2(TIMEOUT_CYC + 1);
   localparam int LAST = FRAME_BITS - 1;

   if (TIMEOUT_CYC < 16) begin : g_bad_to
      $error("ps2_frame_rx: TIMEOUT_CYC too small");
   end

   logic [3:0]      pos_q;
   logic [LAST-1:0] sr_q;
   logic [TW-1:0]   idle_q;
   logic            par_ok;
   logic            stop_ok;

   assign par_ok  = ^sr_q[DATA_BITS+1:1];
   assign stop_ok = dat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         sr_q   <= '0;
         idle_q <= '0;
         data   <= '0;
         valid  <= 1'b0;
         err    <= 1'b0;
      end else begin
         valid <= 1'b0;
         err   <= 1'b0;
         if (inhibit) begin
            pos_q  <= '0;
            idle_q <= '0;
         end else if (fall) begin
            idle_q <= '0;
            if (pos_q == 4'd0) begin
               if (dat) begin
                  err <= 1'b1;
               end else begin
                  sr_q[0] <= 1'b0;
                  pos_q   <= 4'd1;
               end
            end else if (pos_q == 4'(LAST)) begin
               pos_q <= '0;
               if (par_ok && stop_ok) begin
                  valid <= 1'b1;
                  data  <= sr_q[DATA_BITS:1];
               end else begin
                  err <= 1'b1;
               end
            end else begin
               sr_q[pos_q] <= dat;
               pos_q       <= pos_q + 4'd1;
            end
         end else if (pos_q != 4'd0) begin
            if (idle_q == TW'(TIMEOUT_CYC-1)) begin
               pos_q  <= '0;
               idle_q <= '0;
               err    <= 1'b1;
            end else begin
               idle_q <= idle_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ps2_rx.sv
module ps2_rx
   import ps2_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 8,
   parameter int TIMEOUT_CYC = 10000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ps2_clk_i,
   input  logic       ps2_dat_i,
   input  logic       inhibit_i,
   output logic       ps2_clk_oe,
   output logic [7:0] rx_data,
   output logic       rx_valid,
   output logic       rx_err
);
   logic [1:0] raw_w;
   logic [1:0] clean_w;
   logic       clk_prev_q;
   logic       fall_w;

   assign raw_w = {ps2_dat_i, ps2_clk_i};

   for (genvar k = 0; k < 2; k++) begin : g_line
      ps2_deglitch #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_flt (
         .clk   (clk),
         .rst_n (rst_n),
         .raw   (raw_w[k]),
         .clean (clean_w[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_prev_q <= 1'b1;
         ps2_clk_oe <= 1'b0;
      end else begin
         clk_prev_q <= clean_w[0];
         ps2_clk_oe <= inhibit_i;
      end
   end

   assign fall_w = clk_prev_q & ~clean_w[0];

   ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .fall    (fall_w),
      .dat     (clean_w[1]),
      .inhibit (inhibit_i),
      .data    (rx_data),
      .valid   (rx_valid),
      .err     (rx_err)
   );
endmodule

// File: rtl/ps2_rx_chk.sv
module ps2_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       inhibit_i,
   input logic       ps2_clk_oe,
   input logic [7:0] rx_data,
   input logic       rx_valid,
   input logic       rx_err
);
   AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && rx_err)); // R9
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R9
   AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err |=> !rx_err); // R9
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_data)); // R9
   AST_OE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit_i |=> ps2_clk_oe); // R7
   AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !inhibit_i |=> !ps2_clk_oe); // R7
   AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit_i |=> !(rx_valid || rx_err)); // R7
endmodule

bind ps2_rx ps2_rx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .inhibit_i  (inhibit_i),
   .ps2_clk_oe (ps2_clk_oe),
   .rx_data    (rx_data),
   .rx_valid   (rx_valid),
   .rx_err     (rx_err)
);

// File: tb/sim_ps2_rx.sv
`timescale 1ns/1ps
module sim_ps2_rx;
   localparam int TO_CYC = 400;
   localparam int HP     = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dev_clk = 1'b1;
   logic dev_dat = 1'b1;
   logic inhibit = 1'b0;
   logic line_clk;
   logic ps2_clk_oe;
   logic [7:0] rx_data;
   logic rx_valid;
   logic rx_err;

   int n_tests = 0;
   int n_fail = 0;
   int n_valid = 0;
   int n_err = 0;
   int n_valid_inh = 0;
   logic [7:0] last_byte = 8'h00;
   bit done = 1'b0;

   always #5 clk = ~clk;
   assign line_clk = dev_clk & ~ps2_clk_oe;

   ps2_rx #(.TIMEOUT_CYC(TO_CYC)) u0 (
      .clk(clk), .rst_n(rst_n), .ps2_clk_i(line_clk), .ps2_dat_i(dev_dat),
      .inhibit_i(inhibit), .ps2_clk_oe(ps2_clk_oe), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_err(rx_err)
   );

   always @(posedge clk) begin
      if (rx_valid) begin n_valid <= n_valid + 1; last_byte <= rx_data; end
      if (rx_err) n_err <= n_err + 1;
      if (inhibit && (rx_valid || rx_err)) n_valid_inh <= n_valid_inh + 1;
   end

   // [10] expect valid, [9] corrupt stop, [8] corrupt parity, [7:0] byte
   localparam logic [10:0] VEC [8] = '{
      {1'b1, 1'b0, 1'b0, 8'h1C},
      {1'b1, 1'b0, 1'b0, 8'hF0},
      {1'b0, 1'b0, 1'b1, 8'h5A},
      {1'b1, 1'b0, 1'b0, 8'h00},
      {1'b0, 1'b1, 1'b0, 8'h3C},
      {1'b1, 1'b0, 1'b0, 8'hFF},
      {1'b0, 1'b0, 1'b1, 8'h81},
      {1'b1, 1'b0, 1'b0, 8'hA5}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      dev_dat = b;
      wait_cyc(HP/2);
      dev_clk = 1'b0;
      wait_cyc(HP);
      dev_clk = 1'b1;
      wait_cyc(HP/2);
   endtask

   task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
      send_bit(1'b0);
      for (int i = 0; i < 8; i++) send_bit(d[i]);
      send_bit(~(^d) ^ bad_par);
      send_bit(~bad_stop);
      dev_dat = 1'b1;
      wait_cyc(HP);
   endtask

   task automatic good_frame(input logic [7:0] d, input string tag);
      int v0, e0;
      v0 = n_valid; e0 = n_err;
      send_frame(d, 1'b0, 1'b0);
      chk(n_valid == v0 + 1, tag, n_valid - v0, 1);
      chk(n_err == e0, tag, n_err - e0, 0);
      chk(last_byte == d, tag, last_byte, d);
   endtask

   initial begin
      int v0, e0;
      logic [7:0] keep;
      wait_cyc(5);
      chk(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
      chk(rx_err == 1'b0, "R1 err", rx_err, 0);
      chk(rx_data == 8'h00, "R1 data", rx_data, 0);
      chk(ps2_clk_oe == 1'b0, "R1 oe", ps2_clk_oe, 0);
      rst_n = 1'b1;
      wait_cyc(20);

      for (int k = 0; k < 8; k++) begin
         v0 = n_valid; e0 = n_err; keep = last_byte;
         send_frame(VEC[k][7:0], VEC[k][8], VEC[k][9]);
         if (VEC[k][10]) begin
            chk(n_valid == v0 + 1, "R2 valid count", n_valid - v0, 1);
            chk(n_err == e0, "R2 no err", n_err - e0, 0);
            chk(last_byte == VEC[k][7:0], "R2 data", last_byte, VEC[k][7:0]);
         end else begin
            chk(n_valid == v0, VEC[k][9] ? "R4 no valid" : "R3 no valid", n_valid - v0, 0);
            chk(n_err == e0 + 1, VEC[k][9] ? "R4 err" : "R3 err", n_err - e0, 1);
            chk(rx_data == keep, "R3 data kept", rx_data, keep);
         end
      end

      // R5: stray start bit at 1
      v0 = n_valid; e0 = n_err;
      send_bit(1'b1);
      wait_cyc(TO_CYC + 50);
      chk(n_err == e0 + 1, "R5 err", n_err - e0, 1);
      chk(n_valid == v0, "R5 no valid", n_valid - v0, 0);
      good_frame(8'h29, "R5 recover");

      // R6: stalled half frame
      e0 = n_err;
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      wait_cyc(TO_CYC + 50);
      chk(n_err == e0 + 1, "R6 timeout err", n_err - e0, 1);
      good_frame(8'h76, "R6 recover");

      // R7: inhibit mid-frame
      v0 = n_valid; e0 = n_err;
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      inhibit = 1'b1;
      wait_cyc(2);
      chk(ps2_clk_oe == 1'b1, "R7 oe high", ps2_clk_oe, 1);
      chk(line_clk == 1'b0, "R7 line low", line_clk, 0);
      wait_cyc(TO_CYC + 100);
      inhibit = 1'b0;
      wait_cyc(2);
      chk(ps2_clk_oe == 1'b0, "R7 oe low", ps2_clk_oe, 0);
      wait_cyc(40);
      chk(n_valid == v0 && n_err == e0, "R7 quiet", n_valid - v0 + n_err - e0, 0);
      chk(n_valid_inh == 0, "R7 no pulse while inhibited", n_valid_inh, 0);
      good_frame(8'hE0, "R7 recover");

      // R8: short glitches on both lines
      dev_clk = 1'b0; wait_cyc(3); dev_clk = 1'b1; wait_cyc(30);
      dev_dat = 1'b0; wait_cyc(4); dev_dat = 1'b1; wait_cyc(30);
      chk(n_err == e0, "R8 no spurious err", n_err - e0, 0);
      good_frame(8'h4B, "R8 after glitch");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule